// File: doc/BRIEF.md
# Timer Control Word Decoder with Read-Back

This block sits in front of a bank of three programmable down-counters and interprets every byte written to the shared control port. A control word either programs one channel (operating mode, byte access order, decimal counting), asks one channel to freeze its count for reading, or issues a read-back command. A read-back command can freeze the counts and/or capture the status of any subset of the channels in one write. The counters themselves live elsewhere. This block hands them registered one-cycle strobes and the decoded programming fields.

For each channel the block holds one captured status byte and a lock flag. A read of a channel's data port while that channel's status is locked returns the status byte. That read does not advance the counter's byte sequence, and it releases the lock. Reads made while no status is locked pass the counter's own byte straight through, and only those reads are signalled to the counter. A locked status stays fixed under further read-back requests until it is read or the channel is programmed again. Reads of the control port return zero.

Top module: `tmr_cw_readback`

## Requirements
- R1: After reset no strobe is active and no status is locked. A data read of any channel returns that channel's `cnt_byte` lane with `cnt_rd_stb` high for that channel.
- R2: A control write whose bits 7:6 equal channel number c (0..2) and whose bits 5:4 are not 00 pulses `prog_stb[c]` high for exactly the cycle after the write. In that same cycle `prog_mode`, `prog_acc` and `prog_bcd` equal bits 3:1, 5:4 and 0 of the word.
- R3: A control write for channel c with bits 5:4 equal to 00 pulses `latch_stb[c]` in the cycle after the write and does not pulse `prog_stb`, whatever bits 3:0 hold.
- R4: A read-back write (bits 7:6 = 11) with bit 5 low pulses `latch_stb[c]` in the cycle after the write for every channel c whose select bit c+1 is high, all in that same cycle.
- R5: A read-back write with bit 4 low captures, for every selected unlocked channel, the status byte {OUT at bit 7, null count at bit 6, access at bits 5:4, mode at bits 3:1, BCD at bit 0} from that channel's status inputs at the write, and locks it. Bit 4 has no effect on `latch_stb`.
- R6: A locked status byte is not replaced by later read-back status captures, even if the status inputs change.
- R7: A data read of a locked channel returns the status byte with `cnt_rd_stb` low for that channel and unlocks it. The next data read returns the count byte with `cnt_rd_stb` high.
- R8: A programming write (R2) for a channel clears that channel's locked status.
- R9: A control-port read returns 0 on `rd_data` and leaves every locked status in place.
- R10: Without a control write no strobe is raised. A read-back word with bits 5 and 4 both high raises no strobe and locks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 8 | Control word |
| ctl_rd | input | 1 | Control-port read strobe |
| dat_rd | input | 3 | Per-channel data-port read strobe |
| cnt_byte | input | 24 | Count byte offered by each counter, channel c in bits 8c+7:8c |
| ch_out | input | 3 | Output level of each counter |
| ch_null | input | 3 | Null-count flag of each counter |
| ch_mode | input | 9 | Current mode of each counter, 3 bits per channel |
| ch_acc | input | 6 | Current access type of each counter, 2 bits per channel |
| ch_bcd | input | 3 | Current decimal flag of each counter |
| prog_stb | output | 3 | Per-channel programming strobe |
| prog_mode | output | 3 | Mode field for the programmed channel |
| prog_acc | output | 2 | Access field for the programmed channel |
| prog_bcd | output | 1 | Decimal flag for the programmed channel |
| latch_stb | output | 3 | Per-channel count-latch strobe |
| cnt_rd_stb | output | 3 | Data read forwarded to the counter's byte sequencer |
| rd_data | output | 8 | Read data for the current port read |

## Verification
A lock flag stuck set or stuck clear shows on the very next data read of that channel: a status byte arrives where a count byte was expected, or the other way round, and `cnt_rd_stb` takes the wrong level in the same cycle. A status register that is reloaded while locked only shows once the inputs change between two read-back commands. For that reason the status inputs are changed before the second capture. Decode faults show as a wrong strobe pattern one cycle after the write.

// File: rtl/tmr_cw_pkg.sv
package tmr_cw_pkg;
  localparam int CW_W = 8;
  localparam int MAX_CH = 3;

  // control word, bit 7 down to bit 0
  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } cw_t;

  // captured status, bit 7 down to bit 0
  typedef struct packed {
    logic       out;
    logic       nul;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } stat_t;

  localparam logic [1:0] SEL_READBACK = 2'b11;
  localparam logic [1:0] ACC_LATCH    = 2'b00;
endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
  import tmr_cw_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW_W-1:0]   wdata,
  output logic [NUM_CH-1:0] prog_now,
  output logic [NUM_CH-1:0] stat_now,
  output logic [NUM_CH-1:0] prog_stb,
  output logic [NUM_CH-1:0] latch_stb,
  output logic [2:0]        prog_mode,
  output logic [1:0]        prog_acc,
  output logic              prog_bcd
);
  cw_t cw;
  logic              is_rb;
  logic [NUM_CH-1:0] latch_now;
  logic              fld_en;

  assign cw    = cw_t'(wdata);
  assign is_rb = (cw.sel == SEL_READBACK);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    logic rb_sel;
    assign hit    = (cw.sel == 2'(i));
    assign rb_sel = is_rb & wdata[i+1];
    assign prog_now[i]  = wr_en & hit & (cw.acc != ACC_LATCH);
    assign latch_now[i] = wr_en & ((hit & (cw.acc == ACC_LATCH)) |
                                   (rb_sel & ~cw.acc[1]));
    assign stat_now[i]  = wr_en & rb_sel & ~cw.acc[0];
  end

  assign fld_en = |prog_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_stb  <= '0;
      latch_stb <= '0;
    end else begin
      prog_stb  <= prog_now;
      latch_stb <= latch_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_mode <= '0;
      prog_acc  <= '0;
      prog_bcd  <= 1'b0;
    end else if (fld_en) begin
      prog_mode <= cw.mode;
      prog_acc  <= cw.acc;
      prog_bcd  <= cw.bcd;
    end
  end

  // R2
  prog_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prog_stb));

  // R3
  prog_latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb & latch_stb) == '0);

  // R10
  no_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (prog_stb == '0) && (latch_stb == '0));

  // R2
  prog_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb != '0) |-> $stable(prog_mode) || $past(fld_en));
endmodule

// File: rtl/tmr_stat_slot.sv
module tmr_stat_slot
  import tmr_cw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap,
  input  logic  clr,
  input  logic  rd,
  input  stat_t stat_in,
  output logic  locked,
  output stat_t stat_q
);
  logic locked_n;
  logic load_en;

  assign load_en = cap & ~locked & ~clr;

  always_comb begin
    locked_n = locked;
    if (clr)
      locked_n = 1'b0;
    else if (rd && locked)
      locked_n = 1'b0;
    else if (cap)
      locked_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      locked <= 1'b0;
    else
      locked <= locked_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= '0;
    else if (load_en)
      stat_q <= stat_in;
  end

  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr && !rd) |=> locked && $stable(stat_q));

  // R8
  prog_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !locked);

  // R7
  read_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && locked) |=> !locked);
endmodule

// File: rtl/tmr_cw_readback.sv
module tmr_cw_readback
  import tmr_cw_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [CW_W-1:0]     ctl_wdata,
  input  logic                ctl_rd,
  input  logic [NUM_CH-1:0]   dat_rd,
  input  logic [NUM_CH*8-1:0] cnt_byte,
  input  logic [NUM_CH-1:0]   ch_out,
  input  logic [NUM_CH-1:0]   ch_null,
  input  logic [NUM_CH*3-1:0] ch_mode,
  input  logic [NUM_CH*2-1:0] ch_acc,
  input  logic [NUM_CH-1:0]   ch_bcd,
  output logic [NUM_CH-1:0]   prog_stb,
  output logic [2:0]          prog_mode,
  output logic [1:0]          prog_acc,
  output logic                prog_bcd,
  output logic [NUM_CH-1:0]   latch_stb,
  output logic [NUM_CH-1:0]   cnt_rd_stb,
  output logic [CW_W-1:0]     rd_data
);
  localparam int CH_USE = (NUM_CH < MAX_CH) ? NUM_CH : MAX_CH;

  logic [NUM_CH-1:0] prog_now;
  logic [NUM_CH-1:0] stat_now;
  logic [NUM_CH-1:0] locked;
  stat_t             held [NUM_CH];
  logic [CW_W-1:0]   lane [NUM_CH];

  tmr_cw_decode #(.NUM_CH(CH_USE)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_wr),
    .wdata     (ctl_wdata),
    .prog_now  (prog_now),
    .stat_now  (stat_now),
    .prog_stb  (prog_stb),
    .latch_stb (latch_stb),
    .prog_mode (prog_mode),
    .prog_acc  (prog_acc),
    .prog_bcd  (prog_bcd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    stat_t live;
    assign live = '{out:  ch_out[i],
                    nul:  ch_null[i],
                    acc:  ch_acc[i*2 +: 2],
                    mode: ch_mode[i*3 +: 3],
                    bcd:  ch_bcd[i]};

    tmr_stat_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (stat_now[i]),
      .clr     (prog_now[i]),
      .rd      (dat_rd[i]),
      .stat_in (live),
      .locked  (locked[i]),
      .stat_q  (held[i])
    );

    assign cnt_rd_stb[i] = dat_rd[i] & ~locked[i];
    assign lane[i] = !dat_rd[i] ? '0 :
                     locked[i]  ? CW_W'(held[i]) : cnt_byte[i*8 +: 8];
  end

  always_comb begin
    rd_data = '0;
    if (!ctl_rd)
      for (int i = 0; i < NUM_CH; i++)
        rd_data = rd_data | lane[i];
  end

  // R9
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |-> rd_data == '0);

  // R9
  ctl_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && dat_rd == '0 && !ctl_wr) |=> $stable(locked));

  // R7
  status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd[0] && locked[0] && !ctl_rd) |-> !cnt_rd_stb[0] && rd_data == CW_W'(held[0]));

  // R7
  one_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_rd, dat_rd}));
endmodule

// File: tb/tmr_cw_readback_test.sv
module tmr_cw_readback_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic ctl_rd = 1'b0;
  logic [2:0] dat_rd = '0;
  logic [23:0] cnt_byte = 24'h33_22_11;
  logic [2:0] ch_out = 3'b101;
  logic [2:0] ch_null = 3'b010;
  logic [8:0] ch_mode = {3'd4, 3'd1, 3'd3};
  logic [5:0] ch_acc = {2'd2, 2'd1, 2'd3};
  logic [2:0] ch_bcd = 3'b010;
  logic [2:0] prog_stb, latch_stb, cnt_rd_stb;
  logic [2:0] prog_mode;
  logic [1:0] prog_acc;
  logic prog_bcd;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cw_readback uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rd(ctl_rd), .dat_rd(dat_rd), .cnt_byte(cnt_byte), .ch_out(ch_out),
    .ch_null(ch_null), .ch_mode(ch_mode), .ch_acc(ch_acc), .ch_bcd(ch_bcd),
    .prog_stb(prog_stb), .prog_mode(prog_mode), .prog_acc(prog_acc),
    .prog_bcd(prog_bcd), .latch_stb(latch_stb), .cnt_rd_stb(cnt_rd_stb),
    .rd_data(rd_data)
  );

  // {word, prog_stb, latch_stb, mode, acc, bcd}
  localparam logic [19:0] VEC [NV] = '{
    {8'h34, 3'b001, 3'b000, 3'd2, 2'd3, 1'b0},  // R2
    {8'h7B, 3'b010, 3'b000, 3'd5, 2'd3, 1'b1},  // R2
    {8'h96, 3'b100, 3'b000, 3'd3, 2'd1, 1'b0},  // R2
    {8'hA5, 3'b100, 3'b000, 3'd2, 2'd2, 1'b1},  // R2
    {8'h00, 3'b000, 3'b001, 3'd0, 2'd0, 1'b0},  // R3
    {8'h40, 3'b000, 3'b010, 3'd0, 2'd0, 1'b0},  // R3
    {8'h80, 3'b000, 3'b100, 3'd0, 2'd0, 1'b0},  // R3
    {8'h0E, 3'b000, 3'b001, 3'd0, 2'd0, 1'b0},  // R3
    {8'hDE, 3'b000, 3'b111, 3'd0, 2'd0, 1'b0},  // R4
    {8'hD4, 3'b000, 3'b010, 3'd0, 2'd0, 1'b0},  // R4
    {8'hFE, 3'b000, 3'b000, 3'd0, 2'd0, 1'b0},  // R10
    {8'hC0, 3'b000, 3'b000, 3'd0, 2'd0, 1'b0}   // R10
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cw_write(input logic [7:0] w);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic dread(input int ch, input string req,
                       input logic [7:0] exp_d, input logic exp_stb);
    @(negedge clk);
    dat_rd = 3'(1 << ch);
    #1;
    check(req, {8'h00, rd_data}, {8'h00, exp_d});
    check(req, {15'h0, cnt_rd_stb[ch]}, {15'h0, exp_stb});
    @(negedge clk);
    dat_rd = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", {10'h0, prog_stb, latch_stb}, 16'h0);
    dread(0, "R1", 8'h11, 1'b1);
    dread(1, "R1", 8'h22, 1'b1);
    dread(2, "R1", 8'h33, 1'b1);
    for (int k = 0; k < NV; k++) begin
      cw_write(VEC[k][19:12]);
      check("R2/R3/R4/R10 strobes", {10'h0, prog_stb, latch_stb},
            {10'h0, VEC[k][11:6]});
      if (VEC[k][11:9] != 3'b000)
        check("R2 fields", {10'h0, prog_mode, prog_acc, prog_bcd},
              {10'h0, VEC[k][5:0]});
    end
    @(negedge clk);
    check("R10 idle", {10'h0, prog_stb, latch_stb}, 16'h0);
    dread(0, "R10 nothing locked", 8'h11, 1'b1);
    // R5: status of all three channels
    cw_write(8'hEE);
    check("R5 no latch_stb", {13'h0, latch_stb}, 16'h0);
    ch_out = 3'b010;
    cw_write(8'hEE);  // R6: must not overwrite
    dread(0, "R5/R7 status ch0", 8'hB6, 1'b0);
    dread(0, "R7 count after status", 8'h11, 1'b1);
    // R9
    @(negedge clk);
    ctl_rd = 1'b1;
    #1;
    check("R9 ctl read", {8'h0, rd_data}, 16'h0);
    @(negedge clk);
    ctl_rd = 1'b0;
    dread(1, "R6/R9 status ch1 kept", 8'h53, 1'b0);
    // R8
    cw_write(8'hB6);
    check("R8 prog strobe", {13'h0, prog_stb}, 16'h4);
    dread(2, "R8 unlocked by program", 8'h33, 1'b1);
    cw_write(8'hE8);
    dread(2, "R5 new capture ch2", 8'h28, 1'b0);
    // R4 and R5 together
    cw_write(8'hC2);
    check("R4 count with status", {13'h0, latch_stb}, 16'h1);
    dread(0, "R5 combined status", 8'h36, 1'b0);
    dread(0, "R7 combined count", 8'h11, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule